// File: doc/BRIEF.md
# Timer Period to Prescale/Count Converter

This block takes a requested timer period in nanoseconds and the frequency of the clock that drives a prescaled 16-bit timer, in hertz. From these it produces the 32-bit word that sets that timer: a 16-bit prescale divider in the upper half and a 16-bit reload count in the lower half. It first forms the number of clock ticks in the period. It then picks the smallest prescale divider that brings the count into 16 bits, and divides the tick count by that divider to get the count.

All arithmetic runs one step per cycle inside the block:

- The product of period and frequency is built by a shift-add multiplier.
- The scaling down to ticks is done by a restoring shift-subtract divider.
- The count is produced by a second restoring divider of the same kind.

A caller pulses `start_i` while the block is idle and waits for the one-cycle `done_o` pulse. At that point `word_o` and `err_o` hold the result until the next accepted start. When the tick count does not fit in 32 bits, the block reports an error and returns no usable word.

Top module: `tick_word_calc`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy_o`, `done_o` and `err_o` are 0 and `word_o` is 0.
- R2: A cycle with `start_i` high and `busy_o` low is accepted: `busy_o` is 1 in the next cycle, and the operands on `period_i` and `freq_i` in that cycle are the ones used.
- R3: `start_i` and operand changes while `busy_o` is high have no effect: the result matches the operands captured at acceptance.
- R4: The tick count is floor(period × frequency / 1,000,000,000), with the product kept at full 64-bit precision.
- R5: When the tick count exceeds 0xFFFFFFFF, `err_o` is 1 and `word_o` is 0 at done.
- R6: Otherwise the prescale value is (tick count >> 16) + 1, placed in `word_o[31:16]` truncated to 16 bits. A value of 0x10000 therefore appears as 0, which the timer reads as divide by 65536.
- R7: `word_o[15:0]` is floor(tick count / prescale value), with `err_o` 0. If that quotient exceeds 0xFFFF, `err_o` is 1 and `word_o` is 0 instead.
- R8: `done_o` is a single-cycle pulse, high exactly in the cycle in which `busy_o` falls. `word_o` and `err_o` change only in a cycle where `done_o` is high.
- R9: Every accepted start reaches `done_o` within 200 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a conversion; taken only while idle |
| period_i | input | 32 | Requested period in nanoseconds |
| freq_i | input | 32 | Timer input clock frequency in hertz |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when result and error flag are valid |
| word_o | output | 32 | Prescale (31:16) and count (15:0) |
| err_o | output | 1 | Result not representable |

## Verification
A fault in the multiplier or the first divider corrupts the tick count. It shows up at the next done pulse as a wrong prescale field, a wrong count field or a wrongly set error flag. Cases near 2^16 and 2^32 ticks make an off-by-one land in a visible bit. A sequencer fault shows up sooner:

- A lost pulse or a stuck state trips the 200-cycle bound.
- A restart taken while busy is caught on the very next cycle through `busy_o`, or later through a result that follows the later operands.

// File: rtl/tick_calc_pkg.sv
package tick_calc_pkg;

    localparam int PERIOD_W   = 32;
    localparam int FREQ_W     = 32;
    localparam int PROD_W     = PERIOD_W + FREQ_W;
    localparam int TICK_W     = 32;
    localparam int FIELD_W    = 16;
    localparam int PS_W       = FIELD_W + 1;
    localparam int WORD_W     = 2 * FIELD_W;
    localparam int SCALE_W    = 32;
    localparam int LAT_LIMIT  = 200;

    localparam logic [SCALE_W-1:0] NS_PER_SEC = 32'd1_000_000_000;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_MUL,
        CS_DIV_NS,
        CS_DIV_PS
    } calc_state_e;

    typedef struct packed {
        logic [FIELD_W-1:0] prescale;
        logic [FIELD_W-1:0] count;
    } timer_word_t;

    function automatic logic ticks_too_wide(input logic [PROD_W-1:0] t);
        return |t[PROD_W-1:TICK_W];
    endfunction

    function automatic logic [PS_W-1:0] prescale_of(input logic [TICK_W-1:0] t);
        return {1'b0, t[TICK_W-1:FIELD_W]} + PS_W'(1);
    endfunction

    function automatic timer_word_t pack_word(input logic [FIELD_W-1:0] ps,
                                              input logic [FIELD_W-1:0] cnt);
        timer_word_t w;
        w.prescale = ps;
        w.count    = cnt;
        return w;
    endfunction

endpackage

// File: rtl/tc_shift_mul.sv
module tc_shift_mul #(
    parameter int A_W = 32,
    parameter int B_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [A_W-1:0]     a,
    input  logic [B_W-1:0]     b,
    output logic               done,
    output logic [A_W+B_W-1:0] prod
);
    localparam int P_W = A_W + B_W;
    localparam int CW  = $clog2(B_W);

    logic [P_W-1:0] acc_q;
    logic [P_W-1:0] mcand_q;
    logic [B_W-1:0] mplr_q;
    logic [CW-1:0]  step_q;
    logic           run_q;
    logic           done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            mcand_q <= '0;
            mplr_q  <= '0;
            step_q  <= '0;
            run_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                acc_q   <= '0;
                mcand_q <= P_W'(a);
                mplr_q  <= b;
                step_q  <= '0;
                run_q   <= 1'b1;
            end else if (run_q) begin
                if (mplr_q[0]) begin
                    acc_q <= acc_q + mcand_q;
                end
                mcand_q <= mcand_q << 1;
                mplr_q  <= mplr_q >> 1;
                if (step_q == CW'(B_W - 1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign prod = acc_q;

endmodule

// File: rtl/tc_restoring_div.sv
module tc_restoring_div #(
    parameter int NUM_W = 64,
    parameter int DEN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int CW = $clog2(NUM_W);

    logic [NUM_W-1:0] quo_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CW-1:0]    step_q;
    logic             run_q;
    logic             done_q;

    logic [DEN_W:0]   shifted;
    logic [DEN_W:0]   diff;
    logic             fits;

    always_comb begin
        shifted = {rem_q, quo_q[NUM_W-1]};
        diff    = shifted - {1'b0, den_q};
        fits    = ~diff[DEN_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q  <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            step_q <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                quo_q  <= num;
                rem_q  <= '0;
                den_q  <= den;
                step_q <= '0;
                run_q  <= 1'b1;
            end else if (run_q) begin
                if (fits) begin
                    rem_q <= diff[DEN_W-1:0];
                end else begin
                    rem_q <= shifted[DEN_W-1:0];
                end
                quo_q <= {quo_q[NUM_W-2:0], fits};
                if (step_q == CW'(NUM_W - 1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign quo  = quo_q;

endmodule

// File: rtl/tick_word_calc.sv
module tick_word_calc
    import tick_calc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic [FREQ_W-1:0]   freq_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [WORD_W-1:0]   word_o,
    output logic                err_o
);
    calc_state_e        state_q;
    logic [FIELD_W-1:0] ps_q;
    timer_word_t        word_q;
    logic               err_q;
    logic               done_q;

    logic               mul_go, mul_done;
    logic [PROD_W-1:0]  mul_prod;
    logic               ns_go, ns_done;
    logic [PROD_W-1:0]  ns_quo;
    logic               ps_go, ps_done;
    logic [TICK_W-1:0]  ps_quo;
    logic [PS_W-1:0]    ps_next;
    logic               tick_ovf;

    always_comb begin
        tick_ovf = ticks_too_wide(ns_quo);
        ps_next  = prescale_of(ns_quo[TICK_W-1:0]);
        mul_go   = (state_q == CS_IDLE) && start_i;
        ns_go    = (state_q == CS_MUL) && mul_done;
        ps_go    = (state_q == CS_DIV_NS) && ns_done && !tick_ovf;
    end

    tc_shift_mul #(.A_W(PERIOD_W), .B_W(FREQ_W)) mul_i (
        .clk(clk), .rst(rst), .start(mul_go),
        .a(period_i), .b(freq_i),
        .done(mul_done), .prod(mul_prod)
    );

    tc_restoring_div #(.NUM_W(PROD_W), .DEN_W(SCALE_W)) div_ns_i (
        .clk(clk), .rst(rst), .start(ns_go),
        .num(mul_prod), .den(NS_PER_SEC),
        .done(ns_done), .quo(ns_quo)
    );

    tc_restoring_div #(.NUM_W(TICK_W), .DEN_W(PS_W)) div_ps_i (
        .clk(clk), .rst(rst), .start(ps_go),
        .num(ns_quo[TICK_W-1:0]), .den(ps_next),
        .done(ps_done), .quo(ps_quo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CS_IDLE;
            ps_q    <= '0;
            word_q  <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                CS_IDLE: begin
                    if (start_i) state_q <= CS_MUL;
                end
                CS_MUL: begin
                    if (mul_done) state_q <= CS_DIV_NS;
                end
                CS_DIV_NS: begin
                    if (ns_done) begin
                        if (tick_ovf) begin
                            state_q <= CS_IDLE;
                            err_q   <= 1'b1;
                            word_q  <= '0;
                            done_q  <= 1'b1;
                        end else begin
                            ps_q    <= ps_next[FIELD_W-1:0];
                            state_q <= CS_DIV_PS;
                        end
                    end
                end
                CS_DIV_PS: begin
                    if (ps_done) begin
                        state_q <= CS_IDLE;
                        done_q  <= 1'b1;
                        if (|ps_quo[TICK_W-1:FIELD_W]) begin
                            err_q  <= 1'b1;
                            word_q <= '0;
                        end else begin
                            err_q  <= 1'b0;
                            word_q <= pack_word(ps_q, ps_quo[FIELD_W-1:0]);
                        end
                    end
                end
                default: state_q <= CS_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q != CS_IDLE);
    assign done_o = done_q;
    assign word_o = word_q;
    assign err_o  = err_q;

endmodule

// File: rtl/tick_calc_chk.sv
module tick_calc_chk
    import tick_calc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [WORD_W-1:0] word_o,
    input logic              err_o
);
    localparam int LC_W = $clog2(LAT_LIMIT + 2);
    logic [LC_W-1:0] lat_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_cnt <= '0;
        end else if (busy_o) begin
            if (lat_cnt != LC_W'(LAT_LIMIT + 1)) lat_cnt <= lat_cnt + 1'b1;
        end else begin
            lat_cnt <= '0;
        end
    end

    assert_start_taken_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    assert_err_word_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (done_o && err_o) |-> (word_o == '0));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    assert_busy_fall_done_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(word_o) && $stable(err_o)));

    assert_latency_bound_R9: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (lat_cnt < LC_W'(LAT_LIMIT)));

endmodule

bind tick_word_calc tick_calc_chk chk_i (
    .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .word_o(word_o), .err_o(err_o)
);

// File: tb/tick_word_calc_tb_top.sv
module tick_word_calc_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] period_i = '0;
    logic [31:0] freq_i = '0;
    logic        busy_o, done_o, err_o;
    logic [31:0] word_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    tick_word_calc dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .period_i(period_i),
        .freq_i(freq_i), .busy_o(busy_o), .done_o(done_o),
        .word_o(word_o), .err_o(err_o)
    );

    function automatic logic [32:0] model(input logic [31:0] p, input logic [31:0] f);
        logic [63:0] t;
        logic [32:0] ps;
        logic [63:0] c;
        t = (64'(p) * 64'(f)) / 64'd1000000000;
        if (t > 64'hFFFF_FFFF) return {1'b1, 32'h0};
        ps = 33'(t >> 16) + 33'd1;
        c  = t / 64'(ps);
        if (c > 64'hFFFF) return {1'b1, 32'h0};
        return {1'b0, ps[15:0], c[15:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [32:0] act,
                         input logic [32:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_case(input logic [31:0] p, input logic [31:0] f,
                            input string req, input bit disturb);
        logic [32:0] exp;
        logic [32:0] got;
        int n;
        exp = model(p, f);
        @(negedge clk);
        period_i = p;
        freq_i   = f;
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
        check(busy_o === 1'b1, "R2 busy after start", {32'h0, busy_o}, 33'd1);
        if (disturb) begin
            period_i = ~p;
            freq_i   = f ^ 32'h5A5A_5A5A;
            start_i  = 1'b1;
            repeat (3) @(negedge clk);
            start_i  = 1'b0;
        end
        n = 0;
        while (done_o !== 1'b1 && n < 300) begin
            @(negedge clk);
            n++;
        end
        check(n < 200, "R9 latency", 33'(n), 33'd200);
        got = {err_o, word_o};
        check(got === exp, req, got, exp);
        @(negedge clk);
        check(done_o === 1'b0 && busy_o === 1'b0, "R8 done pulse width",
              {31'h0, done_o, busy_o}, 33'd0);
        check({err_o, word_o} === got, "R8 outputs held", {err_o, word_o}, got);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check({busy_o, done_o, err_o} === 3'b000 && word_o === 32'h0, "R1 in reset",
              {err_o, word_o}, 33'd0);
        rst = 1'b0;
        @(negedge clk);
        check({busy_o, done_o, err_o} === 3'b000 && word_o === 32'h0, "R1 after reset",
              {err_o, word_o}, 33'd0);

        run_case(32'd0, 32'd33_000_000, "R6 zero period", 1'b0);
        run_case(32'd1_000_000_000, 32'h0000_FFFF, "R7 count 0xFFFF prescale 1", 1'b0);
        run_case(32'd1_000_000_000, 32'h0001_0000, "R6 prescale 2", 1'b0);
        run_case(32'd1_000_000_000, 32'hFFFF_FFFF, "R6 prescale 0x10000 truncated", 1'b0);
        run_case(32'd2_000_000_000, 32'h8000_0000, "R5 ticks 2^32", 1'b0);
        run_case(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 max operands", 1'b0);
        run_case(32'd999, 32'd1_000_000, "R4 fractional tick floor", 1'b0);
        run_case(32'd1_000_000, 32'd132_000_000, "R3 ignored restart", 1'b1);
        run_case(32'd123_456_789, 32'd66_000_000, "R7 mid range", 1'b0);

        for (int i = 0; i < 40; i++) begin
            logic [31:0] p, f;
            p = $urandom;
            f = $urandom;
            if (i % 4 != 0) begin
                p = p >> ($urandom % 32);
                f = f >> ($urandom % 32);
            end
            run_case(p, f, (i % 3 == 0) ? "R4 random" : "R7 random", (i % 7) == 3);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule